// File: doc/BRIEF.md
# PCI Reset and Clock-Gating Sequencer

This block drives the reset and clock inputs of an on-chip PCI core so that the core's internal state machine always starts from idle. It runs on the free-running PCI clock. Once power is good, it counts clock cycles before it releases the system reset. It keeps a separate count before it releases the PCI reset. The two releases do not depend on each other. When software asks for low power, the block first asserts the PCI reset. It lets a further counted run of clock pulses through and then stops the gated PCI clock low, with no shortened pulse. When the enable request returns, the clock restarts first, and the PCI reset is released only after a fresh count.

A static mode input selects whether the PCI core is used. In unused mode the PCI reset never releases. The gated clock is parked low as soon as the system reset has been released. Loss of power-good asserts both resets at once, without waiting for a clock edge, and the whole sequence then starts again from the beginning.

The power-good, enable and low-power inputs are synchronized into the PCI clock domain before use. Each interval length is a parameter with a default of ten clocks. Each interval counter saturates and raises a done flag when its interval has completed.

Top module: `pcirs_seq`

## Requirements
- R1: After `pwr_good` rises, `sys_rst_n` stays low for at least T_CVRH clock cycles and goes high no later than T_CVRH+4 gated-clock rising edges after `pwr_good` rose.
- R2: In used mode (`mode_used`=1), `pci_rst_n` goes high only after at least T_CVPH gated-clock rising edges since the clock last became valid. With the enable request high from power-up, it goes high within T_CVPH+4 edges of `pwr_good` rising.
- R3: The two resets are released independently. `sys_rst_n` releases with `pci_en_req` low, and `pci_rst_n` then stays low for as long as `pci_en_req` stays low. `pci_rst_n` may release before `sys_rst_n` when T_CVPH < T_CVRH.
- R4: Lowering `pci_en_req` while the PCI core runs drives `pci_rst_n` low within 4 cycles. The gated clock keeps running and `sys_rst_n` stays high.
- R5: When `lp_req` goes high, `pci_rst_n` goes low first, within 4 cycles. The gated clock then gives between T_PLCI and T_PLCI+2 further rising edges and stays low afterwards.
- R6: The gated clock is never stopped before `sys_rst_n` is high. A low-power request at power-up lets at least T_CVRH edges through before the clock stops.
- R7: After gating, when `lp_req` falls with `pci_en_req` high, the clock restarts first. `pci_rst_n` goes high after between T_CVPH and T_CVPH+2 gated edges counted from the fall of `lp_req`. `pci_rst_n` is never high while the clock is stopped.
- R8: In unused mode (`mode_used`=0), `pci_rst_n` never goes high. Within 4 edges after `sys_rst_n` releases, the gated clock stops low and stays stopped.
- R9: When `pwr_good` falls, `sys_rst_n` and `pci_rst_n` go low at once, without a clock edge. The next rise of `pwr_good` restarts the full sequence.
- R10: Every high pulse of `pci_clk_gated` lasts a full high phase of `pci_clk`.
- R11: While `pwr_good` is low, both resets are low and the gated clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pci_clk | input | 1 | Free-running PCI clock; all sequencing runs on it |
| pwr_good | input | 1 | Power-good indication; low asserts both resets asynchronously |
| mode_used | input | 1 | Static mode: 1 = PCI core used, 0 = PCI core unused (parked) |
| pci_en_req | input | 1 | Request to take the PCI core out of reset |
| lp_req | input | 1 | Request to reset the PCI core and stop its clock |
| sys_rst_n | output | 1 | System reset, active low |
| pci_rst_n | output | 1 | PCI core reset, active low |
| pci_clk_gated | output | 1 | Glitch-free gated PCI clock for the core |

## Verification
The bench builds the block with T_CVRH=12, T_CVPH=9 and T_PLCI=5. These short, distinct intervals keep each scenario to a few dozen cycles, and they show from the edge counts which counter set each reset edge or clock stop. Because T_CVPH is less than T_CVRH, a power-up with the enable request already high releases the PCI reset before the system reset, which shows that the two releases are independent. Because T_PLCI is less than T_CVRH, a power-up with low power already requested shows the clock gate waiting for the system-reset release instead of for the shorter park count.

// File: rtl/pcirs_pkg.sv
`timescale 1ns/1ps
package pcirs_pkg;

    // Sequencer states for the PCI side
    typedef enum logic [2:0] {
        ST_WAKE   = 3'd0,   // clock on, PCI reset held, counting valid clocks
        ST_RUN    = 3'd1,   // clock on, PCI reset released
        ST_PARK   = 3'd2,   // PCI reset reasserted, counting before clock stop
        ST_GATED  = 3'd3,   // clock stopped low, PCI reset held
        ST_UNUSED = 3'd4    // core unused: parked until power loss
    } pcirs_state_e;

    // Synchronized request bundle
    typedef struct packed {
        logic en;
        logic lp;
    } pcirs_req_t;

    localparam int REQ_W = $bits(pcirs_req_t);

    // Counter width able to hold 0..lim
    function automatic int cnt_width(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

    // States in which the PCI clock must be passed through
    function automatic logic clock_wanted(input pcirs_state_e s);
        return (s == ST_WAKE) || (s == ST_RUN) || (s == ST_PARK);
    endfunction

endpackage

// File: rtl/pcirs_sync.sv
`timescale 1ns/1ps
module pcirs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pcirs_satcnt.sv
`timescale 1ns/1ps
module pcirs_satcnt #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int W = pcirs_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (cnt != LIM_V)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM_V);
endmodule

// File: rtl/pcirs_clkgate.sv
`timescale 1ns/1ps
module pcirs_clkgate (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);
    logic en_lat;

    // Transparent only while the clock is low: enable changes never cut a high phase
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/pcirs_fsm.sv
`timescale 1ns/1ps
module pcirs_fsm
    import pcirs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_used,
    input  logic         en,
    input  logic         lp,
    input  logic         sys_done,
    input  logic         wake_done,
    input  logic         park_done,
    output pcirs_state_e state,
    output logic         pci_rst_n,
    output logic         clk_en
);
    pcirs_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAKE: begin
                if (!mode_used) begin
                    if (sys_done) nxt = ST_UNUSED;
                end else if (lp) begin
                    nxt = ST_PARK;
                end else if (en && wake_done) begin
                    nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (lp)       nxt = ST_PARK;
                else if (!en) nxt = ST_WAKE;
            end
            ST_PARK: begin
                if (!lp)                        nxt = ST_WAKE;
                else if (park_done && sys_done) nxt = ST_GATED;
            end
            ST_GATED: begin
                if (!lp) nxt = ST_WAKE;
            end
            ST_UNUSED: nxt = ST_UNUSED;
            default:   nxt = ST_WAKE;
        endcase
    end

    // Outputs registered from the next state so they cannot glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_WAKE;
            pci_rst_n <= 1'b0;
            clk_en    <= 1'b1;
        end else begin
            state     <= nxt;
            pci_rst_n <= (nxt == ST_RUN);
            clk_en    <= clock_wanted(nxt);
        end
    end
endmodule

// File: rtl/pcirs_seq.sv
`timescale 1ns/1ps
module pcirs_seq
    import pcirs_pkg::*;
#(
    parameter int T_CVRH      = 10,  // clocks before system reset release
    parameter int T_CVPH      = 10,  // valid clocks before PCI reset release
    parameter int T_PLCI      = 10,  // clocks between PCI reset and clock stop
    parameter int SYNC_STAGES = 2
) (
    input  logic pci_clk,
    input  logic pwr_good,
    input  logic mode_used,
    input  logic pci_en_req,
    input  logic lp_req,
    output logic sys_rst_n,
    output logic pci_rst_n,
    output logic pci_clk_gated
);
    logic         pg_ok;
    pcirs_req_t   req_raw;
    pcirs_req_t   req_s;
    pcirs_state_e state;
    logic         sys_done;
    logic         wake_done;
    logic         park_done;
    logic         sys_rst_q;
    logic         clk_en;

    // Power-good: asserts asynchronously, releases through the synchronizer
    pcirs_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_pg_sync (
        .clk   (pci_clk),
        .rst_n (pwr_good),
        .d     (1'b1),
        .q     (pg_ok)
    );

    assign req_raw = '{en: pci_en_req, lp: lp_req};

    pcirs_sync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_W)) u_req_sync (
        .clk   (pci_clk),
        .rst_n (pg_ok),
        .d     (req_raw),
        .q     (req_s)
    );

    // System reset interval: counts from power-good, never cleared
    pcirs_satcnt #(.LIMIT(T_CVRH)) u_sys_cnt (
        .clk   (pci_clk),
        .rst_n (pg_ok),
        .clr   (1'b0),
        .done  (sys_done)
    );

    // Valid-clock interval before PCI reset release, restarted on each wake entry
    pcirs_satcnt #(.LIMIT(T_CVPH)) u_wake_cnt (
        .clk   (pci_clk),
        .rst_n (pg_ok),
        .clr   (state != ST_WAKE),
        .done  (wake_done)
    );

    // Interval between PCI reset assertion and clock stop
    pcirs_satcnt #(.LIMIT(T_PLCI)) u_park_cnt (
        .clk   (pci_clk),
        .rst_n (pg_ok),
        .clr   (state != ST_PARK),
        .done  (park_done)
    );

    always_ff @(posedge pci_clk or negedge pg_ok) begin
        if (!pg_ok) sys_rst_q <= 1'b0;
        else        sys_rst_q <= sys_done;
    end

    pcirs_fsm u_fsm (
        .clk       (pci_clk),
        .rst_n     (pg_ok),
        .mode_used (mode_used),
        .en        (req_s.en),
        .lp        (req_s.lp),
        .sys_done  (sys_done),
        .wake_done (wake_done),
        .park_done (park_done),
        .state     (state),
        .pci_rst_n (pci_rst_n),
        .clk_en    (clk_en)
    );

    pcirs_clkgate u_gate (
        .clk_i (pci_clk),
        .en_i  (clk_en),
        .clk_o (pci_clk_gated)
    );

    assign sys_rst_n = sys_rst_q;
endmodule

// File: rtl/pcirs_checker.sv
`timescale 1ns/1ps
module pcirs_checker #(
    parameter int T_CVRH = 10,
    parameter int T_CVPH = 10,
    parameter int T_PLCI = 10
) (
    input logic clk,
    input logic pwr_good,
    input logic mode_used,
    input logic sys_rst_n,
    input logic pci_rst_n,
    input logic clk_en
);
    localparam int CAP = 1 << 20;

    int sys_cnt;    // cycles since power-good
    int held_cnt;   // cycles with clock passed and PCI reset held

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            sys_cnt  <= 0;
            held_cnt <= 0;
        end else begin
            if (sys_cnt < CAP) sys_cnt <= sys_cnt + 1;
            if (!clk_en || pci_rst_n) held_cnt <= 0;
            else if (held_cnt < CAP)  held_cnt <= held_cnt + 1;
        end
    end

    AST_SYS_RELEASE_LATE: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(sys_rst_n) |-> sys_cnt >= T_CVRH); // R1

    AST_PCI_RELEASE_LATE: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(pci_rst_n) |-> held_cnt >= T_CVPH); // R2

    AST_PARK_BEFORE_STOP: assert property (@(posedge clk) disable iff (!pwr_good)
        mode_used && $fell(clk_en) |-> held_cnt >= T_PLCI); // R5

    AST_STOP_AFTER_SYS: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(clk_en) |-> sys_rst_n); // R6

    AST_RUN_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!pwr_good)
        pci_rst_n |-> clk_en); // R7

    AST_UNUSED_PARKED: assert property (@(posedge clk) disable iff (!pwr_good)
        !mode_used |-> !pci_rst_n); // R8
endmodule

bind pcirs_seq pcirs_checker #(
    .T_CVRH (T_CVRH),
    .T_CVPH (T_CVPH),
    .T_PLCI (T_PLCI)
) i_pcirs_checker (
    .clk       (pci_clk),
    .pwr_good  (pwr_good),
    .mode_used (mode_used),
    .sys_rst_n (sys_rst_n),
    .pci_rst_n (pci_rst_n),
    .clk_en    (clk_en)
);

// File: tb/test_pcirs_seq.sv
`timescale 1ns/1ps
module test_pcirs_seq;
    localparam int T_CVRH = 12;
    localparam int T_CVPH = 9;
    localparam int T_PLCI = 5;

    logic pci_clk = 1'b0;
    logic pwr_good = 1'b0;
    logic mode_used = 1'b1;
    logic pci_en_req = 1'b0;
    logic lp_req = 1'b0;
    logic sys_rst_n, pci_rst_n, pci_clk_gated;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int g_edges = 0;
    realtime t_hi = 0.0;
    int short_pulses = 0;

    always #10 pci_clk = ~pci_clk;   // 50 MHz

    pcirs_seq #(.T_CVRH(T_CVRH), .T_CVPH(T_CVPH), .T_PLCI(T_PLCI)) i_pcirs_seq (
        .pci_clk       (pci_clk),
        .pwr_good      (pwr_good),
        .mode_used     (mode_used),
        .pci_en_req    (pci_en_req),
        .lp_req        (lp_req),
        .sys_rst_n     (sys_rst_n),
        .pci_rst_n     (pci_rst_n),
        .pci_clk_gated (pci_clk_gated)
    );

    always @(posedge pci_clk_gated) begin
        g_edges++;
        t_hi = $realtime;
    end
    always @(negedge pci_clk_gated) begin
        if ($realtime - t_hi < 9.5) short_pulses++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge pci_clk);
    endtask

    // Power down, set inputs, power up; returns gated edge count at power-up
    task automatic power_up(input logic mode, input logic en, input logic lp, output int e0);
        @(negedge pci_clk);
        pwr_good = 1'b0;
        cycles(4);
        mode_used = mode; pci_en_req = en; lp_req = lp;
        cycles(2);
        e0 = g_edges;
        pwr_good = 1'b1;
    endtask

    task automatic t_reset;
        int e0;
        pwr_good = 1'b0; mode_used = 1'b1; pci_en_req = 1'b0; lp_req = 1'b0;
        cycles(2);
        e0 = g_edges;
        cycles(8);
        chk(sys_rst_n == 1'b0, "R11", "sys_rst_n in power-down", int'(sys_rst_n), 0);
        chk(pci_rst_n == 1'b0, "R11", "pci_rst_n in power-down", int'(pci_rst_n), 0);
        chk(g_edges - e0 >= 7, "R11", "gated clock runs in power-down", g_edges - e0, 8);
    endtask

    task automatic t_up_idle;
        int e0, n;
        power_up(1'b1, 1'b0, 1'b0, e0);
        for (int i = 0; i < 60 && !sys_rst_n; i++) @(negedge pci_clk);
        n = g_edges - e0;
        chk(sys_rst_n && n >= T_CVRH && n <= T_CVRH + 4, "R1", "edges to sys release", n, T_CVRH);
        cycles(40);
        chk(pci_rst_n == 1'b0, "R3", "pci_rst_n held with enable low", int'(pci_rst_n), 0);
        chk(sys_rst_n == 1'b1, "R3", "sys_rst_n released without enable", int'(sys_rst_n), 1);
    endtask

    task automatic t_enable;
        int e0, n;
        e0 = g_edges;
        pci_en_req = 1'b1;
        for (int i = 0; i < 60 && !pci_rst_n; i++) @(negedge pci_clk);
        n = g_edges - e0;
        chk(pci_rst_n && n <= 5, "R2", "edges to pci release after late enable", n, 3);
    endtask

    task automatic t_lowpower;
        int e0, e1, n, e2, lowbad;
        e0 = g_edges;
        lp_req = 1'b1;
        for (int i = 0; i < 10 && pci_rst_n; i++) @(negedge pci_clk);
        e1 = g_edges;
        chk(!pci_rst_n && e1 - e0 <= 4, "R5", "edges to pci reset on low power", e1 - e0, 3);
        cycles(30);
        n = g_edges - e1;
        chk(n >= T_PLCI && n <= T_PLCI + 2, "R5", "edges after pci reset before stop", n, T_PLCI + 1);
        e2 = g_edges;
        lowbad = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge pci_clk); #3;
            if (pci_clk_gated) lowbad++;
        end
        chk(g_edges == e2 && lowbad == 0, "R5", "gated clock stays low", g_edges - e2 + lowbad, 0);
        chk(sys_rst_n == 1'b1, "R5", "sys_rst_n unaffected by gating", int'(sys_rst_n), 1);
    endtask

    task automatic t_wake;
        int e0, n;
        @(negedge pci_clk);
        e0 = g_edges;
        lp_req = 1'b0;
        for (int i = 0; i < 60 && !pci_rst_n; i++) @(negedge pci_clk);
        n = g_edges - e0;
        chk(pci_rst_n && n >= T_CVPH && n <= T_CVPH + 2, "R7", "edges from wake to pci release", n, T_CVPH + 1);
    endtask

    task automatic t_en_drop;
        int e0;
        e0 = g_edges;
        pci_en_req = 1'b0;
        cycles(6);
        chk(pci_rst_n == 1'b0, "R4", "pci_rst_n after enable drop", int'(pci_rst_n), 0);
        chk(sys_rst_n == 1'b1, "R4", "sys_rst_n after enable drop", int'(sys_rst_n), 1);
        chk(g_edges - e0 >= 5, "R4", "clock keeps running", g_edges - e0, 6);
    endtask

    task automatic t_power_loss;
        int e0, n;
        pci_en_req = 1'b1;
        for (int i = 0; i < 60 && !pci_rst_n; i++) @(negedge pci_clk);
        @(posedge pci_clk); #3;
        pwr_good = 1'b0;
        #1;
        chk(sys_rst_n == 1'b0, "R9", "sys_rst_n async on power loss", int'(sys_rst_n), 0);
        chk(pci_rst_n == 1'b0, "R9", "pci_rst_n async on power loss", int'(pci_rst_n), 0);
        // Restart with enable already high
        power_up(1'b1, 1'b1, 1'b0, e0);
        for (int i = 0; i < 60 && !pci_rst_n; i++) @(negedge pci_clk);
        n = g_edges - e0;
        chk(pci_rst_n && n >= T_CVPH && n <= T_CVPH + 4, "R2", "edges to pci release at power-up", n, T_CVPH);
        chk(sys_rst_n == 1'b0, "R3", "pci released before sys (independent)", int'(sys_rst_n), 0);
        for (int i = 0; i < 60 && !sys_rst_n; i++) @(negedge pci_clk);
        n = g_edges - e0;
        chk(sys_rst_n && n >= T_CVRH && n <= T_CVRH + 4, "R9", "sequence restarts after power cycle", n, T_CVRH);
    endtask

    task automatic t_up_lp;
        int e0, n;
        power_up(1'b1, 1'b0, 1'b1, e0);
        cycles(40);
        n = g_edges - e0;
        chk(n >= T_CVRH && n <= T_CVRH + 4, "R6", "edges before stop with early low power", n, T_CVRH + 3);
        chk(sys_rst_n == 1'b1, "R6", "sys released when clock stopped", int'(sys_rst_n), 1);
    endtask

    task automatic t_unused;
        int e0, n, e1, hi_cnt;
        power_up(1'b0, 1'b1, 1'b0, e0);
        hi_cnt = 0;
        for (int i = 0; i < 60 && !sys_rst_n; i++) begin
            @(negedge pci_clk);
            if (pci_rst_n) hi_cnt++;
        end
        n = g_edges - e0;
        chk(sys_rst_n && n >= T_CVRH && n <= T_CVRH + 4, "R1", "edges to sys release, unused mode", n, T_CVRH);
        e1 = g_edges;
        for (int i = 0; i < 30; i++) begin
            @(negedge pci_clk);
            if (pci_rst_n) hi_cnt++;
        end
        chk(g_edges - e1 <= 4, "R8", "edges after sys release, unused mode", g_edges - e1, 1);
        e1 = g_edges;
        for (int i = 0; i < 20; i++) begin
            @(posedge pci_clk); #3;
            if (pci_clk_gated) hi_cnt++;
            if (pci_rst_n) hi_cnt++;
        end
        chk(g_edges == e1, "R8", "gated clock parked", g_edges - e1, 0);
        chk(hi_cnt == 0, "R8", "pci_rst_n or clock high in unused mode", hi_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_up_idle();
        t_enable();
        t_lowpower();
        t_wake();
        t_en_drop();
        t_power_loss();
        t_up_lp();
        t_unused();
        chk(short_pulses == 0, "R10", "shortened gated pulses", short_pulses, 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: requirement all, actual timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule